// File: doc/BRIEF.md
# Measurement Gate Sequencer

This block runs the repeating measurement cycle of a multi-digit counter. It clears the counter, opens the count window, closes it, and then keeps the result on view before the next cycle begins. The count window can be timed in three ways. It can be a decade multiple of one millisecond taken from a reference tick stream. It can be a decade number of pulses on a second input channel, for ratio measurements. It can follow a gate level chosen from a front-panel switch or an external gate line, for event counting.

The reference tick comes either from the internal 1 MHz timebase or from an external reference. A prescaler turns it into millisecond pulses. A single elapsed-count register times both the open window and the hold period. The hold period is picked from six fixed values or set to infinite, in which case the result stays frozen until the manual reset control is used. A gate monitor output follows the window for observation.

All tick, select and reset-control inputs are synchronous to `clk`. The two gate levels are treated as asynchronous and pass through a two-stage synchronizer.

Top module: `meas_seq`

## Requirements
- R1: While reset is held, `count_en`, `count_clr`, `result_valid` and `gate_mon` are low. After reset is released, the first `count_clr` pulse follows within five clock cycles.
- R2: In frequency mode (`mode_sel` = 0, or 3), the window stays open for exactly 10^`gate_sel` milliseconds of selected reference ticks (`gate_sel` 0..4 gives 1 ms to 10 s, and values 5..7 give 10 s), where one millisecond is `MS_DIV` reference ticks.
- R3: `ref_ext_sel` = 1 times the window and the hold period from `ref_ext_tick`, and `ref_int_tick` is then ignored. `ref_ext_sel` = 0 selects `ref_int_tick`.
- R4: The hold period lasts `HOLD_UNIT_MS` × {1, 2, 5, 10, 20, 50} milliseconds for `hold_sel` 0..5, counted from the `result_valid` cycle up to the next `count_clr`.
- R5: `hold_sel` 6 or 7 holds the result indefinitely, with no `count_clr`, until `man_reset` is asserted.
- R6: `result_valid` is high for exactly one cycle, in the cycle right after the window closes. A window cut short by `man_reset` produces no `result_valid`.
- R7: `count_clr` is high for one cycle. In the timed modes `count_en` is high in the cycle right after it. `count_en`, `count_clr` and `result_valid` are never high together.
- R8: In ratio mode (`mode_sel` = 1), the window stays open for exactly 10^`gate_sel` pulses of `chan_b_tick`.
- R9: In event mode (`mode_sel` = 2), the window waits after `count_clr` until the selected gate level is high, then stays open for as many cycles as that level was high. `gate_ext_sel` = 1 selects `ext_gate` and 0 selects `man_gate`. The unselected level has no effect.
- R10: `gate_mon` equals `count_en` in every cycle.
- R11: `man_reset` in any state causes `count_clr` in the next cycle, aborting an open window or a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_int_tick | input | 1 | Internal reference tick, one cycle per reference period |
| ref_ext_tick | input | 1 | External reference tick |
| ref_ext_sel | input | 1 | 1 selects the external reference |
| mode_sel | input | 2 | 0 frequency, 1 ratio, 2 events, 3 frequency |
| gate_sel | input | 3 | Window length exponent (decades) |
| hold_sel | input | 3 | Hold length choice, 6..7 infinite |
| chan_b_tick | input | 1 | Second-channel pulse for ratio mode |
| gate_ext_sel | input | 1 | Event gate source, 1 external, 0 manual |
| ext_gate | input | 1 | External gate level (asynchronous) |
| man_gate | input | 1 | Manual gate level (asynchronous) |
| man_reset | input | 1 | Restart the cycle, one-cycle pulse |
| count_en | output | 1 | Counter enable, high while the window is open |
| count_clr | output | 1 | Counter clear, one cycle before each window |
| result_valid | output | 1 | One-cycle strobe when the window closes |
| gate_mon | output | 1 | Window monitor |

## Verification
Frequency mode is swept over every window decade, and also over an out-of-range select, counting the reference ticks seen with the window open. This separates an off-by-one window, a wrong decade and a missing clamp. The same count taken on an external reference with a third of the tick density, and on a second channel pulsing every fifth cycle, tells apart a wrong source select and a ratio window that counts time instead of pulses. Every hold choice is measured in ticks between strobe and clear. Event mode is driven with gate pulses of known length while the unselected gate toggles, and infinite hold, aborted windows and manual restarts are checked for the exact cycle of the next clear.

// File: rtl/meas_seq_pkg.sv
`timescale 1ns/1ps
package meas_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_ARM   = 3'd2,
    ST_GATE  = 3'd3,
    ST_HOLD  = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    MD_FREQ   = 2'd0,
    MD_RATIO  = 2'd1,
    MD_EVENTS = 2'd2,
    MD_SPARE  = 2'd3
  } meas_mode_t;

  // number of finite hold choices; selects at or above this are infinite
  localparam int HOLD_CHOICES = 6;

  function automatic int pow10(input int e);
    int r;
    r = 1;
    for (int i = 0; i < e; i++) r = r * 10;
    return r;
  endfunction

  // 1-2-5 hold multipliers in units of HOLD_UNIT_MS
  function automatic int hold_mult(input int sel);
    case (sel)
      0:       return 1;
      1:       return 2;
      2:       return 5;
      3:       return 10;
      4:       return 20;
      default: return 50;
    endcase
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/meas_seq_rst_sync.sv
`timescale 1ns/1ps
module meas_seq_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/meas_seq_sync.sv
`timescale 1ns/1ps
module meas_seq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/meas_seq_timebase.sv
`timescale 1ns/1ps
module meas_seq_timebase #(
  parameter int MS_DIV = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_tick,
  input  logic ext_tick,
  input  logic ext_sel,
  input  logic restart,
  output logic ms_pulse
);
  localparam int PRE_W = (MS_DIV > 1) ? $clog2(MS_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(MS_DIV - 1);

  logic             ref_tick;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic             pre_en;

  assign ref_tick = ext_sel ? ext_tick : int_tick;
  assign ms_pulse = ref_tick && (pre_q == PRE_LAST);

  // clock enable: only on a tick or a phase restart
  assign pre_en = restart || ref_tick;

  always_comb begin
    pre_d = pre_q;
    if (restart)       pre_d = '0;
    else if (ms_pulse) pre_d = '0;
    else               pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/meas_seq_ctrl.sv
`timescale 1ns/1ps
module meas_seq_ctrl
  import meas_seq_pkg::*;
#(
  parameter int GATE_DECADES = 5,
  parameter int HOLD_UNIT_MS = 100,
  parameter int CNT_W        = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic [2:0] gate_sel,
  input  logic [2:0] hold_sel,
  input  logic       ms_pulse,
  input  logic       b_tick,
  input  logic       gate_lvl,
  input  logic       man_reset,
  output logic       restart,
  output logic       gate_open,
  output logic       clr_out,
  output logic       valid_out
);
  localparam int GIDX_W = (GATE_DECADES > 1) ? $clog2(GATE_DECADES) : 1;
  localparam int HIDX_W = $clog2(HOLD_CHOICES);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  logic [CNT_W-1:0] gate_lut [GATE_DECADES];
  logic [CNT_W-1:0] hold_lut [HOLD_CHOICES];

  for (genvar g = 0; g < GATE_DECADES; g++) begin : g_gate_lut
    assign gate_lut[g] = CNT_W'(pow10(g));
  end
  for (genvar h = 0; h < HOLD_CHOICES; h++) begin : g_hold_lut
    assign hold_lut[h] = CNT_W'(hold_mult(h) * HOLD_UNIT_MS);
  end

  logic [GIDX_W-1:0] gate_idx;
  logic [HIDX_W-1:0] hold_idx;
  logic [CNT_W-1:0]  gate_tgt, hold_tgt;
  logic              hold_inf;
  logic              is_events, is_ratio;
  logic              step, gate_done, hold_done;

  always_comb begin
    if (int'(gate_sel) >= GATE_DECADES) gate_idx = GIDX_W'(GATE_DECADES - 1);
    else                                gate_idx = GIDX_W'(gate_sel);
    hold_inf = (int'(hold_sel) >= HOLD_CHOICES);
    hold_idx = hold_inf ? '0 : HIDX_W'(hold_sel);
  end

  assign gate_tgt  = gate_lut[gate_idx];
  assign hold_tgt  = hold_lut[hold_idx];
  assign is_events = (mode_sel == MD_EVENTS);
  assign is_ratio  = (mode_sel == MD_RATIO);
  assign step      = is_ratio ? b_tick : ms_pulse;
  assign gate_done = step && (cnt_q == gate_tgt - 1'b1);
  assign hold_done = ms_pulse && !hold_inf && (cnt_q == hold_tgt - 1'b1);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  state_d = ST_CLEAR;
      ST_CLEAR: state_d = is_events ? ST_ARM : ST_GATE;
      ST_ARM:   if (gate_lvl) state_d = ST_GATE;
      ST_GATE: begin
        if (is_events) begin
          if (!gate_lvl) state_d = ST_HOLD;
        end else if (gate_done) begin
          state_d = ST_HOLD;
        end else if (step) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (hold_done)                 state_d = ST_CLEAR;
        else if (ms_pulse && !hold_inf) cnt_d = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (man_reset) state_d = ST_CLEAR;
    if (state_d != state_q) cnt_d = '0;
    valid_d = (state_q == ST_GATE) && (state_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign restart   = (state_d != state_q);
  assign gate_open = (state_q == ST_GATE);
  assign clr_out   = (state_q == ST_CLEAR);
  assign valid_out = valid_q;
endmodule

// File: rtl/meas_seq.sv
`timescale 1ns/1ps
module meas_seq
  import meas_seq_pkg::*;
#(
  parameter int MS_DIV       = 1000,
  parameter int GATE_DECADES = 5,
  parameter int HOLD_UNIT_MS = 100,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_int_tick,
  input  logic       ref_ext_tick,
  input  logic       ref_ext_sel,
  input  logic [1:0] mode_sel,
  input  logic [2:0] gate_sel,
  input  logic [2:0] hold_sel,
  input  logic       chan_b_tick,
  input  logic       gate_ext_sel,
  input  logic       ext_gate,
  input  logic       man_gate,
  input  logic       man_reset,
  output logic       count_en,
  output logic       count_clr,
  output logic       result_valid,
  output logic       gate_mon
);
  localparam int MAX_GATE = pow10(GATE_DECADES - 1);
  localparam int MAX_HOLD = hold_mult(HOLD_CHOICES - 1) * HOLD_UNIT_MS;
  localparam int CNT_W    = $clog2(max_int(MAX_GATE, MAX_HOLD) + 1);

  logic       rst_q_n;
  logic [1:0] gate_sync;
  logic       gate_lvl;
  logic       ms_pulse;
  logic       restart;
  logic       gate_open;

  meas_seq_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q_n)
  );

  meas_seq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_gsync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .d_async ({ext_gate, man_gate}),
    .d_sync  (gate_sync)
  );

  assign gate_lvl = gate_ext_sel ? gate_sync[1] : gate_sync[0];

  meas_seq_timebase #(.MS_DIV(MS_DIV)) u_tb (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .int_tick (ref_int_tick),
    .ext_tick (ref_ext_tick),
    .ext_sel  (ref_ext_sel),
    .restart  (restart),
    .ms_pulse (ms_pulse)
  );

  meas_seq_ctrl #(
    .GATE_DECADES (GATE_DECADES),
    .HOLD_UNIT_MS (HOLD_UNIT_MS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .mode_sel  (mode_sel),
    .gate_sel  (gate_sel),
    .hold_sel  (hold_sel),
    .ms_pulse  (ms_pulse),
    .b_tick    (chan_b_tick),
    .gate_lvl  (gate_lvl),
    .man_reset (man_reset),
    .restart   (restart),
    .gate_open (gate_open),
    .clr_out   (count_clr),
    .valid_out (result_valid)
  );

  assign count_en = gate_open;
  assign gate_mon = gate_open;
endmodule

// File: rtl/meas_seq_chk.sv
`timescale 1ns/1ps
module meas_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic       man_reset,
  input logic       count_en,
  input logic       count_clr,
  input logic       result_valid
);
  assert_valid_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (!count_en && $past(count_en)));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({count_en, count_clr, result_valid}));

  assert_clr_then_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_clr && (mode_sel != 2'd2) && !man_reset) |=> count_en);

  assert_restart_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    man_reset |=> count_clr);
endmodule

bind meas_seq meas_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .mode_sel     (mode_sel),
  .man_reset    (man_reset),
  .count_en     (count_en),
  .count_clr    (count_clr),
  .result_valid (result_valid)
);

// File: tb/meas_seq_tb.sv
`timescale 1ns/1ps
module meas_seq_tb;
  localparam int MS_DIV = 2;
  localparam int DEC    = 5;
  localparam int HU     = 10;
  localparam int GUARD  = 60000;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_int_tick, ref_ext_tick, ref_ext_sel;
  logic [1:0] mode_sel;
  logic [2:0] gate_sel, hold_sel;
  logic chan_b_tick, gate_ext_sel, ext_gate, man_gate, man_reset;
  logic count_en, count_clr, result_valid, gate_mon;

  int checks = 0, fails = 0, phase = 0;
  int g_int, g_ext, g_b, n_en, h_ticks, n_valid, n_clr, mon_bad;
  bit in_hold = 0, done = 0;
  logic s_en, s_clr, s_valid, s_mon;

  always #4 clk = ~clk;

  meas_seq #(.MS_DIV(MS_DIV), .GATE_DECADES(DEC), .HOLD_UNIT_MS(HU)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_int_tick(ref_int_tick), .ref_ext_tick(ref_ext_tick),
    .ref_ext_sel(ref_ext_sel), .mode_sel(mode_sel), .gate_sel(gate_sel), .hold_sel(hold_sel),
    .chan_b_tick(chan_b_tick), .gate_ext_sel(gate_ext_sel), .ext_gate(ext_gate),
    .man_gate(man_gate), .man_reset(man_reset), .count_en(count_en), .count_clr(count_clr),
    .result_valid(result_valid), .gate_mon(gate_mon));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_acc();
    g_int = 0; g_ext = 0; g_b = 0; n_en = 0; h_ticks = 0; n_valid = 0; n_clr = 0;
  endtask

  // one clock: drive ticks at negedge, sample just before the next rising edge
  task automatic cyc();
    @(negedge clk);
    phase++;
    ref_int_tick = 1'b1;
    ref_ext_tick = (phase % 3 == 0);
    chan_b_tick  = (phase % 5 == 0);
    #3;
    s_en = count_en; s_clr = count_clr; s_valid = result_valid; s_mon = gate_mon;
    if (s_mon !== s_en) mon_bad++;
    if (s_en) begin
      n_en++;
      if (ref_int_tick) g_int++;
      if (ref_ext_tick) g_ext++;
      if (chan_b_tick)  g_b++;
    end
    if (s_valid) begin in_hold = 1; n_valid++; end
    if (s_clr)   begin in_hold = 0; n_clr++; end
    if (in_hold && !s_en && (ref_ext_sel ? ref_ext_tick : ref_int_tick)) h_ticks++;
  endtask

  task automatic restart();
    man_reset = 1'b1; cyc(); man_reset = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int k = 0;
    while (!s_valid && k < GUARD) begin cyc(); k++; end
    if (k >= GUARD) chk(0, req, 0, 1);
  endtask

  task automatic wait_clr(input string req);
    int k = 0;
    while (!s_clr && k < GUARD) begin cyc(); k++; end
    if (k >= GUARD) chk(0, req, 0, 1);
  endtask

  function automatic int p10(input int e);
    int r = 1;
    for (int i = 0; i < e; i++) r *= 10;
    return r;
  endfunction

  function automatic int hmul(input int s);
    case (s) 0: return 1; 1: return 2; 2: return 5; 3: return 10; 4: return 20; default: return 50; endcase
  endfunction

  // timed measurement: one restart, one window, one hold
  task automatic run_timed(input int src, input int exp_g, input int exp_h, input string rg, input string rh);
    int got;
    restart();
    wait_clr(rg);
    clr_acc();
    cyc();
    chk(s_en === 1'b1, "R7 open after clear", s_en, 1);
    wait_valid(rg);
    got = (src == 0) ? g_int : (src == 1) ? g_ext : g_b;
    chk(got == exp_g, rg, got, exp_g);
    chk(n_valid == 1, "R6 single strobe", n_valid, 1);
    cyc();
    chk(s_valid === 1'b0, "R6 strobe one cycle", s_valid, 0);
    wait_clr(rh);
    chk(h_ticks == exp_h, rh, h_ticks, exp_h);
  endtask

  initial begin
    #1_590_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_int_tick = 0; ref_ext_tick = 0; ref_ext_sel = 0; mode_sel = 0;
    gate_sel = 0; hold_sel = 0; chan_b_tick = 0; gate_ext_sel = 0; ext_gate = 0;
    man_gate = 0; man_reset = 0; mon_bad = 0;
    clr_acc();
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk({s_en, s_clr, s_valid, s_mon} == 4'b0, "R1 reset outputs", {s_en, s_clr, s_valid, s_mon}, 0);
    end
    rst_n = 1'b1;
    begin
      int k = 0;
      while (!s_clr && k < 10) begin cyc(); k++; end
      chk(s_clr && k <= 5, "R1 first clear", k, 3);
    end

    // R2: every window decade, plus an out-of-range select clamped to 10 s
    for (int g = 0; g < 8; g++) begin
      if (g == 5 || g == 6) continue;
      gate_sel = 3'(g);
      run_timed(0, p10((g < DEC) ? g : DEC - 1) * MS_DIV, HU * MS_DIV, "R2 window ticks", "R4 hold ticks");
    end

    // R4: every finite hold choice
    gate_sel = 0;
    for (int h = 0; h < 6; h++) begin
      hold_sel = 3'(h);
      run_timed(0, MS_DIV, hmul(h) * HU * MS_DIV, "R2 window ticks", "R4 hold ticks");
    end
    hold_sel = 0;

    // R3: external reference
    ref_ext_sel = 1; gate_sel = 2;
    run_timed(1, 100 * MS_DIV, HU * MS_DIV, "R3 ext ref window", "R3 ext ref hold");
    ref_ext_sel = 0;

    // R8: ratio mode counts second-channel pulses
    mode_sel = 1;
    for (int g = 0; g < 4; g++) begin
      gate_sel = 3'(g);
      run_timed(2, p10(g), HU * MS_DIV, "R8 ratio pulses", "R4 hold ticks");
    end
    mode_sel = 3; gate_sel = 1;
    run_timed(0, 10 * MS_DIV, HU * MS_DIV, "R2 spare mode as frequency", "R4 hold ticks");
    mode_sel = 0;

    // R5: infinite hold, then manual restart
    hold_sel = 7; gate_sel = 0;
    restart(); wait_valid("R5 reach hold");
    clr_acc();
    repeat (3000) cyc();
    chk(n_clr == 0 && n_en == 0, "R5 held", n_clr + n_en, 0);
    restart();
    chk(s_clr === 1'b1, "R5 manual reset clears", s_clr, 1);
    hold_sel = 0;

    // R11: abort an open 10 s window
    gate_sel = 4;
    restart(); wait_clr("R11 start");
    clr_acc();
    repeat (100) cyc();
    restart();
    chk(s_clr === 1'b1 && n_valid == 0, "R11 abort", {s_clr, n_valid[0]}, 2);
    cyc();
    chk(s_en === 1'b1, "R11 reopen", s_en, 1);

    // R9: event mode, manual then external gate
    mode_sel = 2;
    for (int src = 0; src < 2; src++) begin
      int len = src ? 9 : 17;
      gate_ext_sel = src[0];
      restart(); wait_clr("R9 clear");
      clr_acc();
      for (int i = 0; i < 20; i++) begin
        if (src == 0) ext_gate = i[1]; else man_gate = i[1];
        cyc();
      end
      ext_gate = 0; man_gate = 0;
      chk(n_en == 0, "R9 armed, other gate ignored", n_en, 0);
      if (src == 0) man_gate = 1; else ext_gate = 1;
      repeat (len) cyc();
      man_gate = 0; ext_gate = 0;
      wait_valid("R9 close");
      chk(n_en == len, "R9 event window cycles", n_en, len);
      wait_clr("R9 hold end");
      clr_acc();
      repeat (30) cyc();
      chk(n_en == 0, "R9 waits for gate", n_en, 0);
    end

    chk(mon_bad == 0, "R10 monitor mirrors enable", mon_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule